// File: doc/BRIEF.md
# Two-Level Haar Forward Transform Core for 2x2 Pixel Blocks

The core takes one 2x2 neighbourhood of an 8-bit grayscale image per transaction and returns the four coefficients of a two-level 2D Haar forward transform. The first level combines vertically adjacent pixels into smooth and detail terms. The second level combines those terms horizontally. Each of the four results belongs to one quadrant of the N x N coefficient matrix, and the core supplies the matrix coordinates that go with it. A frame producer presents the neighbourhoods in raster order of block positions, with the column index g varying fastest. The core numbers them internally and pulses a completion flag after the last block of the frame.

The arithmetic runs on four shared adder-subtractor units, each followed by a divide-by-two stage. In the first step the units compute the column (level-1) terms. In the second step the same units compute the row (level-2) terms. Coefficients are 11-bit two's complement numbers with two fractional bits, so both halvings are exact. Both the input side and the output side use a valid/ready handshake. While a result waits for the consumer, the core refuses new pixels.

Top module: `haar_quad_fwd`

## Requirements
- R1: During reset in_ready, out_valid and frame_done are 0. One clock after reset is released, in_ready is 1 and the block position outputs read row_top=0 and col_left=0.
- R2: The upper-left coefficient q_ul equals tl+tr+bl+br, which is four times the smooth-of-smooth value (Q2 fixed point: the integer is 4 times the real value).
- R3: The upper-right coefficient q_ur equals (tr+br)-(tl+bl). This is four times half the difference between the even-column smooth term and the odd-column smooth term.
- R4: The lower-left coefficient q_ll equals (bl+br)-(tl+tr), the smooth of the row-2i-minus-row-(2i-1) details. The lower-right coefficient q_lr equals (br-tr)-(bl-tl), the detail of those details. All values are in Q2.
- R5: Extreme inputs neither overflow nor round. The results reach 1020 for q_ul and +510/-510 for the other three, and a single LSB pixel difference yields values of magnitude 1 (0.25).
- R6: A result appears with out_valid=1 exactly three rising edges after the edge on which the input was accepted (in_valid and in_ready both 1).
- R7: While out_valid=1 and out_ready=0, out_valid stays 1, the coefficients and positions stay unchanged, and in_ready stays 0. Pixels offered with in_valid=1 during that time are ignored.
- R8: For block (i,g), counted from 0, the positions are row_top=i, col_left=g, row_bot=N/2+i and col_right=N/2+g. The coefficient locations are: q_ul at (row_top,col_left), q_ur at (row_top,col_right), q_ll at (row_bot,col_left), q_lr at (row_bot,col_right).
- R9: The positions advance only when a result is accepted. g increments first. When g wraps from N/2-1 to 0, i increments. After block (N/2-1,N/2-1) both return to 0 for the next frame.
- R10: frame_done is 1 for exactly one cycle. That cycle follows the edge on which the result of the last block of a frame is accepted. frame_done is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel block offered |
| in_ready | output | 1 | Core can take a pixel block |
| px_tl | input | 8 | Pixel at row 2i-1, column 2g-1 |
| px_tr | input | 8 | Pixel at row 2i-1, column 2g |
| px_bl | input | 8 | Pixel at row 2i, column 2g-1 |
| px_br | input | 8 | Pixel at row 2i, column 2g |
| out_valid | output | 1 | Coefficients available |
| out_ready | input | 1 | Consumer takes the coefficients |
| q_ul | output | 11 | Smooth-of-smooth coefficient, Q2 signed |
| q_ur | output | 11 | Column-detail of smooth coefficient, Q2 signed |
| q_ll | output | 11 | Smooth of row-detail coefficient, Q2 signed |
| q_lr | output | 11 | Detail-of-detail coefficient, Q2 signed |
| row_top | output | 9 | Matrix row of q_ul and q_ur |
| row_bot | output | 9 | Matrix row of q_ll and q_lr |
| col_left | output | 9 | Matrix column of q_ul and q_ll |
| col_right | output | 9 | Matrix column of q_ur and q_lr |
| frame_done | output | 1 | One-cycle pulse after the last block of a frame |

## Verification
Accepting the last block's result falls on the same edge as the wrap of both position counters and the launch of the completion pulse. The bench makes this happen by stalling the consumer on the final block of a frame while offering new pixels, then releasing out_ready. The check is that frame_done rises in the next cycle only, and that the following transaction reports position (0,0). Holding off a pending result while the producer presents another block is also exercised. The stalled coefficients must stay unchanged and the extra pixels must never be taken.

// File: rtl/haar_pkg.sv
package haar_pkg;

    localparam int PIX_W  = 8;
    localparam int FRAC_W = 2;
    localparam int COEF_W = PIX_W + FRAC_W + 1;
    localparam int LANES  = 4;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STEP1,
        ST_STEP2,
        ST_OUT
    } phase_e;

    typedef struct packed {
        coef_t ul;
        coef_t ur;
        coef_t ll;
        coef_t lr;
    } quad_t;

    // Pixel to Q2 fixed point: value times four, sign bit clear.
    function automatic coef_t pix_to_fix(input pix_t p);
        return coef_t'({1'b0, p, {FRAC_W{1'b0}}});
    endfunction

endpackage

// File: rtl/haar_asu.sv
module haar_asu
    import haar_pkg::*;
#(
    parameter int W = COEF_W
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic                sub,
    output logic signed [W-1:0] y
);

    logic signed [W:0] a_ext;
    logic signed [W:0] b_ext;
    logic signed [W:0] wide;
    logic signed [W:0] halved;

    always_comb begin
        a_ext  = {a[W-1], a};
        b_ext  = {b[W-1], b};
        wide   = sub ? (a_ext - b_ext) : (a_ext + b_ext);
        halved = wide >>> 1;
        y      = W'(halved);
    end

endmodule

// File: rtl/haar_ctrl.sv
module haar_ctrl
    import haar_pkg::*;
#(
    parameter int HALF  = 256,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             step1_en,
    output logic             step2_en,
    output logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] idx_g,
    output logic             frame_done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF - 1);

    phase_e phase_q, phase_d;
    logic   take_in;
    logic   give_out;
    logic   last_blk;

    always_comb begin
        in_ready  = (phase_q == ST_LOAD);
        out_valid = (phase_q == ST_OUT);
        step1_en  = (phase_q == ST_STEP1);
        step2_en  = (phase_q == ST_STEP2);
        take_in   = in_valid && in_ready;
        give_out  = out_valid && out_ready;
        last_blk  = (idx_i == LAST_IDX) && (idx_g == LAST_IDX);
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            ST_IDLE:  phase_d = ST_LOAD;
            ST_LOAD:  if (take_in) phase_d = ST_STEP1;
            ST_STEP1: phase_d = ST_STEP2;
            ST_STEP2: phase_d = ST_OUT;
            ST_OUT:   if (give_out) phase_d = last_blk ? ST_IDLE : ST_LOAD;
            default:  phase_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= ST_IDLE;
            idx_i      <= '0;
            idx_g      <= '0;
            frame_done <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            frame_done <= give_out && last_blk;
            if (give_out) begin
                if (idx_g == LAST_IDX) begin
                    idx_g <= '0;
                    idx_i <= (idx_i == LAST_IDX) ? '0 : idx_i + 1'b1;
                end else begin
                    idx_g <= idx_g + 1'b1;
                end
            end
        end
    end

    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R10
    AST_DONE_WRAP: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (idx_i == '0) && (idx_g == '0)); // R9
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_ready) |=> $stable(idx_i) && $stable(idx_g)); // R9

endmodule

// File: rtl/haar_quad_fwd.sv
module haar_quad_fwd
    import haar_pkg::*;
#(
    parameter int IMG_N = 512
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [PIX_W-1:0]           px_tl,
    input  logic [PIX_W-1:0]           px_tr,
    input  logic [PIX_W-1:0]           px_bl,
    input  logic [PIX_W-1:0]           px_br,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic signed [COEF_W-1:0]   q_ul,
    output logic signed [COEF_W-1:0]   q_ur,
    output logic signed [COEF_W-1:0]   q_ll,
    output logic signed [COEF_W-1:0]   q_lr,
    output logic [$clog2(IMG_N)-1:0]   row_top,
    output logic [$clog2(IMG_N)-1:0]   row_bot,
    output logic [$clog2(IMG_N)-1:0]   col_left,
    output logic [$clog2(IMG_N)-1:0]   col_right,
    output logic                       frame_done
);

    localparam int HALF  = IMG_N / 2;
    localparam int IDX_W = $clog2(IMG_N);
    localparam logic [IDX_W-1:0] HALF_OFS = IDX_W'(HALF);

    logic             step1_en;
    logic             step2_en;
    logic [IDX_W-1:0] idx_i;
    logic [IDX_W-1:0] idx_g;

    pix_t  pix_q [LANES];
    coef_t mid_q [LANES];
    coef_t asu_y [LANES];
    quad_t res_q;

    haar_ctrl #(
        .HALF  (HALF),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .step1_en   (step1_en),
        .step2_en   (step2_en),
        .idx_i      (idx_i),
        .idx_g      (idx_g),
        .frame_done (frame_done)
    );

    // Lane k, step 1: column pass. Lanes 0/1 sum, lanes 2/3 take lower minus upper.
    // Lane k, step 2: row pass on the step-1 terms. Even lanes sum, odd lanes take
    // the even-column term minus the odd-column term.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int   A1   = k;
        localparam int   B1   = k ^ 2;
        localparam int   A2   = (k / 2) * 2 + 1;
        localparam int   B2   = (k / 2) * 2;
        localparam logic SUB1 = ((k / 2) == 1);
        localparam logic SUB2 = ((k % 2) == 1);

        coef_t op_a;
        coef_t op_b;
        logic  op_sub;

        always_comb begin
            op_a   = step2_en ? mid_q[A2] : pix_to_fix(pix_q[A1]);
            op_b   = step2_en ? mid_q[B2] : pix_to_fix(pix_q[B1]);
            op_sub = step2_en ? SUB2 : SUB1;
        end

        haar_asu #(
            .W (COEF_W)
        ) u_asu (
            .a   (op_a),
            .b   (op_b),
            .sub (op_sub),
            .y   (asu_y[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LANES; k++) begin
                pix_q[k] <= '0;
                mid_q[k] <= '0;
            end
            res_q <= '0;
        end else begin
            if (in_valid && in_ready) begin
                pix_q[0] <= px_tl;
                pix_q[1] <= px_tr;
                pix_q[2] <= px_bl;
                pix_q[3] <= px_br;
            end
            if (step1_en) begin
                for (int k = 0; k < LANES; k++) mid_q[k] <= asu_y[k];
            end
            if (step2_en) begin
                res_q.ul <= asu_y[0];
                res_q.ur <= asu_y[1];
                res_q.ll <= asu_y[2];
                res_q.lr <= asu_y[3];
            end
        end
    end

    always_comb begin
        q_ul      = res_q.ul;
        q_ur      = res_q.ur;
        q_ll      = res_q.ll;
        q_lr      = res_q.lr;
        row_top   = idx_i;
        col_left  = idx_g;
        row_bot   = HALF_OFS + idx_i;
        col_right = HALF_OFS + idx_g;
    end

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(res_q)); // R7
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |-> ##3 out_valid); // R6
    AST_UL_NONNEG: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (q_ul >= 0)); // R2
    AST_DETAIL_BOUND: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (q_ur <= q_ul) && (-q_ur <= q_ul) && (q_ll <= q_ul)
                      && (-q_ll <= q_ul) && (q_lr <= q_ul) && (-q_lr <= q_ul)); // R5

endmodule

// File: tb/test_haar_quad_fwd.sv
module test_haar_quad_fwd;

    localparam int N    = 8;
    localparam int HALF = N / 2;
    localparam int IW   = $clog2(N);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic out_ready = 1'b0;
    logic [7:0] px_tl = '0, px_tr = '0, px_bl = '0, px_br = '0;
    logic in_ready, out_valid, frame_done;
    logic signed [10:0] q_ul, q_ur, q_ll, q_lr;
    logic [IW-1:0] row_top, row_bot, col_left, col_right;

    int checks = 0;
    int fails  = 0;
    int exp_i  = 0;
    int exp_g  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    haar_quad_fwd #(.IMG_N(N)) i_haar_quad_fwd (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .px_tl(px_tl), .px_tr(px_tr), .px_bl(px_bl), .px_br(px_br),
        .out_valid(out_valid), .out_ready(out_ready),
        .q_ul(q_ul), .q_ur(q_ur), .q_ll(q_ll), .q_lr(q_lr),
        .row_top(row_top), .row_bot(row_bot),
        .col_left(col_left), .col_right(col_right),
        .frame_done(frame_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in_ready in reset", int'(in_ready), 0);
        check("R1 out_valid in reset", int'(out_valid), 0);
        check("R1 frame_done in reset", int'(frame_done), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 in_ready after release", int'(in_ready), 1);
        check("R1 row_top after release", int'(row_top), 0);
        check("R1 col_left after release", int'(col_left), 0);
    endtask

    // One block: offer, accept, wait for the result, compare, optional stall, release.
    task automatic xact(input int tl, input int tr, input int bl, input int br,
                        input int stall, input string tag);
        int  lat;
        int  e_ul, e_ur, e_ll, e_lr;
        bit  last;
        @(negedge clk);
        px_tl = 8'(tl); px_tr = 8'(tr); px_bl = 8'(bl); px_br = 8'(br);
        in_valid = 1'b1;
        lat = 0;
        while (!in_ready && lat < 50) begin @(negedge clk); lat++; end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 50) begin @(negedge clk); lat++; end
        check($sformatf("R6 latency %s", tag), lat, 3);

        e_ul = tl + tr + bl + br;
        e_ur = (tr + br) - (tl + bl);
        e_ll = (bl + br) - (tl + tr);
        e_lr = (br - tr) - (bl - tl);
        check($sformatf("R2 q_ul %s", tag), int'(q_ul), e_ul);
        check($sformatf("R3 q_ur %s", tag), int'(q_ur), e_ur);
        check($sformatf("R4 q_ll %s", tag), int'(q_ll), e_ll);
        check($sformatf("R4 q_lr %s", tag), int'(q_lr), e_lr);
        check($sformatf("R8 row_top %s", tag), int'(row_top), exp_i);
        check($sformatf("R8 col_left %s", tag), int'(col_left), exp_g);
        check($sformatf("R8 row_bot %s", tag), int'(row_bot), HALF + exp_i);
        check($sformatf("R8 col_right %s", tag), int'(col_right), HALF + exp_g);

        if (stall > 0) begin
            px_tl = ~px_tl; px_tr = ~px_tr; px_bl = 8'(bl + 17); px_br = 8'(br + 99);
            in_valid = 1'b1;
            repeat (stall) @(negedge clk);
            check($sformatf("R7 out_valid held %s", tag), int'(out_valid), 1);
            check($sformatf("R7 in_ready low %s", tag), int'(in_ready), 0);
            check($sformatf("R7 q_ul held %s", tag), int'(q_ul), e_ul);
            check($sformatf("R7 q_lr held %s", tag), int'(q_lr), e_lr);
            check($sformatf("R7 col_left held %s", tag), int'(col_left), exp_g);
        end

        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b0;
        last = (exp_i == HALF - 1) && (exp_g == HALF - 1);
        check($sformatf("R10 frame_done %s", tag), int'(frame_done), last ? 1 : 0);
        if (last) begin
            @(negedge clk);
            check($sformatf("R10 done one cycle %s", tag), int'(frame_done), 0);
        end
        if (exp_g == HALF - 1) begin
            exp_g = 0;
            exp_i = (exp_i == HALF - 1) ? 0 : exp_i + 1;
        end else begin
            exp_g = exp_g + 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        xact(255, 255, 255, 255, 0, "R5 all white");
        xact(255,   0,   0, 255, 0, "R5 diagonal");
        xact(  0, 255, 255,   0, 0, "R5 anti diagonal");
        xact(255,   0, 255,   0, 0, "R5 left column bright");
        xact(255, 255,   0,   0, 0, "R5 top row bright");
        xact(  1,   0,   0,   0, 0, "R5 quarter step");
        xact( 10,  20,  30,  40, 4, "R7 stalled result");
        for (int k = 7; k < HALF * HALF; k++) begin
            xact((k * 53 + 7) % 256, (k * 29 + 200) % 256,
                 (k * 71 + 3) % 256, (k * 17 + 90) % 256,
                 (k == HALF * HALF - 1) ? 3 : 0,
                 $sformatf("R9 scan block %0d", k));
        end
        xact(100, 50, 25, 12, 0, "R9 next frame origin");
        finish_run();
    end

endmodule